// File: doc/BRIEF.md
# Serial Audio Port Pin-Function Controller

This block decides what the three clock and frame-sync pins of a multi-channel serial audio port do. The three pins are the transmit bit-clock pin, the transmit frame-sync pin and the receive-clock pin. Each pin is handed either to the serial port or to general-purpose I/O. In serial use, the transmit bit clock and transmit frame sync are routed to the transmit section. They also go to the receive section when the port runs synchronously. In asynchronous operation the receive section takes its bit clock from the receive-clock pin and its frame sync from a separate input.

In synchronous operation the receive-clock pin is no longer needed as a clock, so it becomes serial flag 0. As an output flag it drives a registered copy of a control bit. As an input flag, its level is resynchronised and captured into a status bit. Both updates happen only on a qualifying strobe: frame sync in normal mode, or the slot strobe in network mode. Shift registers, clock dividers and data paths sit outside this block.

Top module: `sap_pinmux`

## Requirements
- R1: A synchronous active-high reset puts every pin in general-purpose mode and disconnected. After reset, `pad_oe`, `pad_out` and `gpio_din` are all zero, `iflag` is 0, the output-flag register is 0, and the serial clock and frame-sync outputs are 0.
- R2: Pin index 0 is the transmit clock pin, 1 is the transmit frame-sync pin and 2 is the receive-clock pin. A pin whose `cfg_serial` bit is 0 is in general-purpose mode. Its 2-bit field `cfg_gpio_mode[2i+1:2i]` selects the mode: 00 or 11 disconnected, 01 input, 10 output.
  - Output mode drives `cfg_gpio_dout[i]` with the output enable set.
  - Input mode passes the pad level to `gpio_din[i]`.
  - Disconnected mode deasserts the output enable and reads 0.
  - `gpio_din[i]` is 0 in every other case.
  - A general-purpose pin contributes 0 to the serial-side signals.
  - Each pin is configured independently.
- R3: The configuration inputs take effect only on a clock edge with `cfg_we` high. Otherwise the previous configuration is held.
- R4: When the transmit clock pin is in serial use, `cfg_tck_out`=1 makes it drive `int_tck` with the enable set, and `tx_bclk` follows `int_tck`. With `cfg_tck_out`=0 the pin is undriven and `tx_bclk` follows the pad.
- R5: When the transmit frame-sync pin is in serial use, `cfg_tfs_out`=1 drives `int_tfs` on it and onto `tx_fs`. With `cfg_tfs_out`=0 the pin is undriven and `tx_fs` follows the pad.
- R6: With `cfg_sync`=1, `rx_bclk` equals `tx_bclk` and `rx_fs` equals `tx_fs`. With `cfg_sync`=0, `rx_fs` follows `rx_fs_async`. In that case the serial receive-clock pin acts as the receive clock: it drives `int_rck` when `cfg_rck_out`=1 and is read from the pad otherwise.
- R7: In synchronous mode the serial receive-clock pin is the flag pin. Its output enable equals `cfg_rck_out`, and as an output it drives the output-flag register, not `int_rck`.
- R8: In synchronous mode with the flag pin as an output, the output-flag register loads the configured `cfg_oflag` on a qualifying strobe and holds it at all other times. The qualifying strobe is `frame_stb` when `cfg_network`=0 and `slot_stb` when `cfg_network`=1. The new level shows on the pin in the cycle after the strobe.
- R9: The receive-clock pad level passes through a two-flop synchroniser. In synchronous mode with the flag pin as an input, a qualifying strobe copies the synchroniser output into `iflag`. A level must therefore be present for two clock edges before the strobe edge to be captured. `iflag` holds otherwise, including in asynchronous mode.
- R10: A non-qualifying strobe has no effect on either flag: `slot_stb` in normal mode, `frame_stb` in network mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Loads all configuration inputs into the register |
| cfg_serial | input | 3 | Per-pin serial (1) or general-purpose (0) selection |
| cfg_gpio_mode | input | 6 | Two bits per pin: 00/11 off, 01 input, 10 output |
| cfg_gpio_dout | input | 3 | General-purpose output levels |
| cfg_sync | input | 1 | 1 = synchronous port operation |
| cfg_network | input | 1 | 1 = network mode (slot strobe qualifies) |
| cfg_tck_out | input | 1 | Transmit clock pin drives (1) or receives (0) |
| cfg_tfs_out | input | 1 | Transmit frame-sync pin drives (1) or receives (0) |
| cfg_rck_out | input | 1 | Receive-clock / flag pin drives (1) or receives (0) |
| cfg_oflag | input | 1 | Output flag value to present at the next strobe |
| int_tck | input | 1 | Internally generated transmit bit clock |
| int_tfs | input | 1 | Internally generated transmit frame sync |
| int_rck | input | 1 | Internally generated receive bit clock |
| rx_fs_async | input | 1 | Receive frame sync used in asynchronous mode |
| frame_stb | input | 1 | Frame boundary strobe |
| slot_stb | input | 1 | Slot boundary strobe |
| pad_in | input | 3 | Pad input levels |
| pad_out | output | 3 | Pad output levels |
| pad_oe | output | 3 | Pad output enables |
| gpio_din | output | 3 | General-purpose input readback |
| tx_bclk | output | 1 | Bit clock for the transmit section |
| rx_bclk | output | 1 | Bit clock for the receive section |
| tx_fs | output | 1 | Frame sync for the transmit section |
| rx_fs | output | 1 | Frame sync for the receive section |
| iflag | output | 1 | Captured input flag status |

## Verification
The hardest situation to reach is an input-flag capture that races the synchroniser: a pad change landing in the same cycle as a qualifying strobe, or one cycle before it. The bench changes the pad on exactly the clock before the strobe and expects the old level to be captured. It then waits two edges and strobes again to see the new level. Wrong-strobe cases are reached by flipping `cfg_network` between pulses, so that each kind of strobe is seen both as qualifying and as ignored.

// File: rtl/sap_pkg.sv
package sap_pkg;

    localparam int NPIN     = 3;
    localparam int PIN_TCK  = 0;
    localparam int PIN_TFS  = 1;
    localparam int PIN_RCK  = 2;
    localparam int MODE_W   = 2;

    typedef enum logic [MODE_W-1:0] {
        GM_OFF  = 2'b00,
        GM_IN   = 2'b01,
        GM_OUT  = 2'b10,
        GM_OFF2 = 2'b11
    } gpio_mode_e;

    typedef struct packed {
        logic [NPIN-1:0]        ser;
        logic [MODE_W*NPIN-1:0] gmode;
        logic [NPIN-1:0]        dout;
        logic                   sync;
        logic                   net;
        logic                   tck_out;
        logic                   tfs_out;
        logic                   rck_out;
        logic                   oflag;
    } port_cfg_t;

    localparam port_cfg_t CFG_RST = '0;

    function automatic gpio_mode_e pin_mode(logic [MODE_W*NPIN-1:0] gm, int idx);
        return gpio_mode_e'(gm[MODE_W*idx +: MODE_W]);
    endfunction

endpackage

// File: rtl/sap_cfg_reg.sv
module sap_cfg_reg
    import sap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      we,
    input  port_cfg_t d,
    output port_cfg_t q
);

    always_ff @(posedge clk) begin
        if (rst)     q <= CFG_RST;
        else if (we) q <= d;
    end

    p_cfg_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));

endmodule

// File: rtl/sap_flag_unit.sv
module sap_flag_unit #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic flag_mode,
    input  logic flag_is_out,
    input  logic net,
    input  logic frame_stb,
    input  logic slot_stb,
    input  logic oflag_ctl,
    input  logic pad_level,
    output logic oflag_pin,
    output logic iflag
);

    logic [SYNC_STAGES-1:0] chain;
    logic                   upd;
    logic                   load_out;
    logic                   load_in;

    assign upd      = net ? slot_stb : frame_stb;
    assign load_out = flag_mode &&  flag_is_out && upd;
    assign load_in  = flag_mode && !flag_is_out && upd;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[SYNC_STAGES-2:0], pad_level};
    end

    always_ff @(posedge clk) begin
        if (rst)           oflag_pin <= 1'b0;
        else if (load_out) oflag_pin <= oflag_ctl;
    end

    always_ff @(posedge clk) begin
        if (rst)          iflag <= 1'b0;
        else if (load_in) iflag <= chain[SYNC_STAGES-1];
    end

    p_oflag_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(oflag_pin));

    p_oflag_load_r8: assert property (@(posedge clk) disable iff (rst)
        (flag_mode && flag_is_out && upd) |=> (oflag_pin == $past(oflag_ctl)));

    p_iflag_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(iflag));

    p_iflag_async_r9: assert property (@(posedge clk) disable iff (rst)
        !flag_mode |=> $stable(iflag));

endmodule

// File: rtl/sap_route.sv
module sap_route
    import sap_pkg::*;
(
    input  logic [NPIN-1:0]        ser,
    input  logic [MODE_W*NPIN-1:0] gmode,
    input  logic [NPIN-1:0]        dout,
    input  logic                   sync,
    input  logic                   tck_out,
    input  logic                   tfs_out,
    input  logic                   rck_out,
    input  logic [NPIN-1:0]        pad_in,
    input  logic                   int_tck,
    input  logic                   int_tfs,
    input  logic                   int_rck,
    input  logic                   rx_fs_async,
    input  logic                   oflag_pin,
    output logic [NPIN-1:0]        pad_oe,
    output logic [NPIN-1:0]        pad_out,
    output logic [NPIN-1:0]        gpio_din,
    output logic                   tx_bclk,
    output logic                   rx_bclk,
    output logic                   tx_fs,
    output logic                   rx_fs
);

    logic [NPIN-1:0] ser_oe;
    logic [NPIN-1:0] ser_val;
    logic [NPIN-1:0] ser_in;

    assign ser_oe[PIN_TCK]  = tck_out;
    assign ser_val[PIN_TCK] = int_tck;
    assign ser_oe[PIN_TFS]  = tfs_out;
    assign ser_val[PIN_TFS] = int_tfs;
    assign ser_oe[PIN_RCK]  = rck_out;
    assign ser_val[PIN_RCK] = sync ? oflag_pin : int_rck;

    for (genvar gi = 0; gi < NPIN; gi++) begin : g_pin
        gpio_mode_e mode_w;
        logic       gp_oe;

        assign mode_w       = pin_mode(gmode, gi);
        assign gp_oe        = (mode_w == GM_OUT);
        assign pad_oe[gi]   = ser[gi] ? ser_oe[gi] : gp_oe;
        assign pad_out[gi]  = !pad_oe[gi] ? 1'b0 : (ser[gi] ? ser_val[gi] : dout[gi]);
        assign gpio_din[gi] = (!ser[gi] && mode_w == GM_IN) ? pad_in[gi] : 1'b0;
        assign ser_in[gi]   = !ser[gi] ? 1'b0 : (ser_oe[gi] ? ser_val[gi] : pad_in[gi]);

        always_comb begin
            if (!ser[gi] && mode_w != GM_OUT)
                p_gpio_undriven_r2: assert (pad_out[gi] == 1'b0 || pad_oe[gi] == 1'b1);
        end
    end

    assign tx_bclk = ser_in[PIN_TCK];
    assign tx_fs   = ser_in[PIN_TFS];
    assign rx_bclk = sync ? ser_in[PIN_TCK] : ser_in[PIN_RCK];
    assign rx_fs   = sync ? ser_in[PIN_TFS] : rx_fs_async;

endmodule

// File: rtl/sap_pinmux.sv
module sap_pinmux
    import sap_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic [NPIN-1:0]        cfg_serial,
    input  logic [MODE_W*NPIN-1:0] cfg_gpio_mode,
    input  logic [NPIN-1:0]        cfg_gpio_dout,
    input  logic                   cfg_sync,
    input  logic                   cfg_network,
    input  logic                   cfg_tck_out,
    input  logic                   cfg_tfs_out,
    input  logic                   cfg_rck_out,
    input  logic                   cfg_oflag,
    input  logic                   int_tck,
    input  logic                   int_tfs,
    input  logic                   int_rck,
    input  logic                   rx_fs_async,
    input  logic                   frame_stb,
    input  logic                   slot_stb,
    input  logic [NPIN-1:0]        pad_in,
    output logic [NPIN-1:0]        pad_out,
    output logic [NPIN-1:0]        pad_oe,
    output logic [NPIN-1:0]        gpio_din,
    output logic                   tx_bclk,
    output logic                   rx_bclk,
    output logic                   tx_fs,
    output logic                   rx_fs,
    output logic                   iflag
);

    port_cfg_t cfg_d;
    port_cfg_t cfg_q;
    logic      oflag_pin;

    assign cfg_d = '{ser:     cfg_serial,
                     gmode:   cfg_gpio_mode,
                     dout:    cfg_gpio_dout,
                     sync:    cfg_sync,
                     net:     cfg_network,
                     tck_out: cfg_tck_out,
                     tfs_out: cfg_tfs_out,
                     rck_out: cfg_rck_out,
                     oflag:   cfg_oflag};

    sap_cfg_reg u_cfg (
        .clk (clk),
        .rst (rst),
        .we  (cfg_we),
        .d   (cfg_d),
        .q   (cfg_q)
    );

    sap_flag_unit #(.SYNC_STAGES(SYNC_STAGES)) u_flag (
        .clk         (clk),
        .rst         (rst),
        .flag_mode   (cfg_q.sync && cfg_q.ser[PIN_RCK]),
        .flag_is_out (cfg_q.rck_out),
        .net         (cfg_q.net),
        .frame_stb   (frame_stb),
        .slot_stb    (slot_stb),
        .oflag_ctl   (cfg_q.oflag),
        .pad_level   (pad_in[PIN_RCK]),
        .oflag_pin   (oflag_pin),
        .iflag       (iflag)
    );

    sap_route u_route (
        .ser         (cfg_q.ser),
        .gmode       (cfg_q.gmode),
        .dout        (cfg_q.dout),
        .sync        (cfg_q.sync),
        .tck_out     (cfg_q.tck_out),
        .tfs_out     (cfg_q.tfs_out),
        .rck_out     (cfg_q.rck_out),
        .pad_in      (pad_in),
        .int_tck     (int_tck),
        .int_tfs     (int_tfs),
        .int_rck     (int_rck),
        .rx_fs_async (rx_fs_async),
        .oflag_pin   (oflag_pin),
        .pad_oe      (pad_oe),
        .pad_out     (pad_out),
        .gpio_din    (gpio_din),
        .tx_bclk     (tx_bclk),
        .rx_bclk     (rx_bclk),
        .tx_fs       (tx_fs),
        .rx_fs       (rx_fs)
    );

    p_reset_off_r1: assert property (@(posedge clk)
        rst |=> (pad_oe == '0 && gpio_din == '0 && !iflag));

    p_sync_share_r6: assert property (@(posedge clk) disable iff (rst)
        cfg_q.sync |-> (rx_bclk == tx_bclk && rx_fs == tx_fs));

    p_flag_dir_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.sync && cfg_q.ser[PIN_RCK]) |-> (pad_oe[PIN_RCK] == cfg_q.rck_out));

endmodule

// File: tb/sap_pinmux_test.sv
`timescale 1ns/1ps
module sap_pinmux_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_we;
    logic [2:0] cfg_serial;
    logic [5:0] cfg_gpio_mode;
    logic [2:0] cfg_gpio_dout;
    logic       cfg_sync, cfg_network, cfg_tck_out, cfg_tfs_out, cfg_rck_out, cfg_oflag;
    logic       int_tck, int_tfs, int_rck, rx_fs_async;
    logic       frame_stb, slot_stb;
    logic [2:0] pad_in;
    logic [2:0] pad_out, pad_oe, gpio_din;
    logic       tx_bclk, rx_bclk, tx_fs, rx_fs, iflag;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    sap_pinmux uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we),
        .cfg_serial(cfg_serial), .cfg_gpio_mode(cfg_gpio_mode), .cfg_gpio_dout(cfg_gpio_dout),
        .cfg_sync(cfg_sync), .cfg_network(cfg_network), .cfg_tck_out(cfg_tck_out),
        .cfg_tfs_out(cfg_tfs_out), .cfg_rck_out(cfg_rck_out), .cfg_oflag(cfg_oflag),
        .int_tck(int_tck), .int_tfs(int_tfs), .int_rck(int_rck), .rx_fs_async(rx_fs_async),
        .frame_stb(frame_stb), .slot_stb(slot_stb), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .gpio_din(gpio_din),
        .tx_bclk(tx_bclk), .rx_bclk(rx_bclk), .tx_fs(tx_fs), .rx_fs(rx_fs), .iflag(iflag)
    );

    typedef struct packed {
        logic [2:0] ser;
        logic [5:0] gm;
        logic [2:0] dout;
        logic       syn, tckd, tfsd, rckd;
        logic [2:0] pin;
        logic [3:0] ints;   // {int_tck, int_tfs, int_rck, rx_fs_async}
        logic [2:0] e_oe;
        logic [2:0] e_out;
        logic [2:0] e_din;
        logic [3:0] e_clk;  // {tx_bclk, rx_bclk, tx_fs, rx_fs}
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{3'b000, 6'b01_10_00, 3'b111, 1'b0,1'b0,1'b0,1'b0, 3'b101, 4'b0000, 3'b010, 3'b010, 3'b100, 4'b0000},
        '{3'b000, 6'b11_01_10, 3'b001, 1'b0,1'b0,1'b0,1'b0, 3'b111, 4'b1111, 3'b001, 3'b001, 3'b010, 4'b0001},
        '{3'b111, 6'b00_00_00, 3'b000, 1'b0,1'b1,1'b1,1'b1, 3'b000, 4'b1010, 3'b111, 3'b101, 3'b000, 4'b1100},
        '{3'b111, 6'b00_00_00, 3'b000, 1'b0,1'b0,1'b0,1'b0, 3'b011, 4'b0101, 3'b000, 3'b000, 3'b000, 4'b1011},
        '{3'b111, 6'b00_00_00, 3'b000, 1'b1,1'b1,1'b0,1'b0, 3'b110, 4'b1001, 3'b001, 3'b001, 3'b000, 4'b1111},
        '{3'b111, 6'b00_00_00, 3'b000, 1'b1,1'b0,1'b1,1'b1, 3'b001, 4'b0011, 3'b110, 3'b000, 3'b000, 4'b1100},
        '{3'b001, 6'b10_01_00, 3'b100, 1'b1,1'b0,1'b0,1'b0, 3'b011, 4'b0000, 3'b100, 3'b100, 3'b010, 4'b1100},
        '{3'b100, 6'b00_00_10, 3'b001, 1'b0,1'b0,1'b0,1'b0, 3'b100, 4'b0000, 3'b001, 3'b001, 3'b000, 4'b0100}
    };
    // V0,V1,V7: R2 GPIO modes; V2: R4/R5 driving; V3: R5/R4 receiving + async R6;
    // V4,V6: R6 sync sharing; V5: R7 flag pin direction
    localparam string VTAG [NVEC] = '{"R2", "R2", "R4", "R5", "R6", "R7", "R6", "R2"};

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [2:0] ser, input logic [5:0] gm, input logic [2:0] dout,
                           input logic syn, input logic net, input logic tckd, input logic tfsd,
                           input logic rckd, input logic of);
        cfg_serial = ser; cfg_gpio_mode = gm; cfg_gpio_dout = dout;
        cfg_sync = syn; cfg_network = net; cfg_tck_out = tckd;
        cfg_tfs_out = tfsd; cfg_rck_out = rckd; cfg_oflag = of;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_frame();
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
    endtask

    task automatic pulse_slot();
        slot_stb = 1'b1;
        @(negedge clk);
        slot_stb = 1'b0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0;
        cfg_serial = '0; cfg_gpio_mode = '0; cfg_gpio_dout = '0;
        cfg_sync = 0; cfg_network = 0; cfg_tck_out = 0; cfg_tfs_out = 0; cfg_rck_out = 0; cfg_oflag = 0;
        int_tck = 0; int_tfs = 0; int_rck = 0; rx_fs_async = 0;
        frame_stb = 0; slot_stb = 0; pad_in = 3'b111;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk("R1", "pad_oe", 8'(pad_oe), 8'h0);
        chk("R1", "pad_out", 8'(pad_out), 8'h0);
        chk("R1", "gpio_din", 8'(gpio_din), 8'h0);
        chk("R1", "clocks", 8'({tx_bclk, rx_bclk, tx_fs, rx_fs, iflag}), 8'h0);

        // Vector table: combinational routing per configuration
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            set_cfg(VECS[i].ser, VECS[i].gm, VECS[i].dout, VECS[i].syn, 1'b0,
                    VECS[i].tckd, VECS[i].tfsd, VECS[i].rckd, 1'b0);
            pad_in = VECS[i].pin;
            {int_tck, int_tfs, int_rck, rx_fs_async} = VECS[i].ints;
            #1;
            chk(VTAG[i], $sformatf("v%0d oe", i),  8'(pad_oe),   8'(VECS[i].e_oe));
            chk(VTAG[i], $sformatf("v%0d out", i), 8'(pad_out),  8'(VECS[i].e_out));
            chk(VTAG[i], $sformatf("v%0d din", i), 8'(gpio_din), 8'(VECS[i].e_din));
            chk(VTAG[i], $sformatf("v%0d clk", i), 8'({tx_bclk, rx_bclk, tx_fs, rx_fs}), 8'(VECS[i].e_clk));
        end

        // R3: configuration inputs without write enable are ignored
        @(negedge clk);
        cfg_serial = 3'b111; cfg_tck_out = 1; cfg_tfs_out = 1; cfg_rck_out = 1;
        @(negedge clk); @(negedge clk);
        #1;
        chk("R3", "oe held", 8'(pad_oe), 8'h1);

        // R8 / R10: output flag, normal mode (frame strobe qualifies)
        int_rck = 1'b1;
        @(negedge clk);
        set_cfg(3'b111, 6'h0, 3'h0, 1, 0, 0, 0, 1, 1);
        #1;
        chk("R8", "oflag before strobe", 8'(pad_out[2]), 8'h0);
        @(negedge clk);
        pulse_slot();
        #1;
        chk("R10", "slot ignored in normal", 8'(pad_out[2]), 8'h0);
        @(negedge clk);
        pulse_frame();
        #1;
        chk("R8", "oflag after frame", 8'(pad_out[2]), 8'h1);
        @(negedge clk);
        set_cfg(3'b111, 6'h0, 3'h0, 1, 0, 0, 0, 1, 0);
        repeat (2) @(negedge clk);
        #1;
        chk("R8", "oflag held between strobes", 8'(pad_out[2]), 8'h1);
        // network mode: slot strobe qualifies
        @(negedge clk);
        set_cfg(3'b111, 6'h0, 3'h0, 1, 1, 0, 0, 1, 0);
        pulse_frame();
        #1;
        chk("R10", "frame ignored in network", 8'(pad_out[2]), 8'h1);
        @(negedge clk);
        pulse_slot();
        #1;
        chk("R8", "oflag after slot", 8'(pad_out[2]), 8'h0);

        // R9: input flag capture through synchroniser
        @(negedge clk);
        set_cfg(3'b111, 6'h0, 3'h0, 1, 0, 0, 0, 0, 0);
        pad_in = 3'b100;
        repeat (3) @(negedge clk);
        #1;
        chk("R9", "iflag before strobe", 8'(iflag), 8'h0);
        chk("R7", "flag pin undriven as input", 8'(pad_oe[2]), 8'h0);
        @(negedge clk);
        pulse_frame();
        #1;
        chk("R9", "iflag captured", 8'(iflag), 8'h1);
        @(negedge clk);
        pad_in = 3'b000;
        pulse_frame();
        #1;
        chk("R9", "sync latency keeps old level", 8'(iflag), 8'h1);
        repeat (2) @(negedge clk);
        pulse_slot();
        #1;
        chk("R10", "slot ignored for iflag", 8'(iflag), 8'h1);
        @(negedge clk);
        pulse_frame();
        #1;
        chk("R9", "iflag recaptured low", 8'(iflag), 8'h0);
        // network mode capture
        @(negedge clk);
        set_cfg(3'b111, 6'h0, 3'h0, 1, 1, 0, 0, 0, 0);
        pad_in = 3'b100;
        repeat (2) @(negedge clk);
        pulse_slot();
        #1;
        chk("R9", "iflag on slot in network", 8'(iflag), 8'h1);
        // asynchronous mode: no capture
        @(negedge clk);
        set_cfg(3'b111, 6'h0, 3'h0, 0, 0, 0, 0, 0, 0);
        pad_in = 3'b000;
        repeat (3) @(negedge clk);
        pulse_frame();
        #1;
        chk("R9", "iflag held in async", 8'(iflag), 8'h1);
        chk("R6", "async rx clock from pad", 8'(rx_bclk), 8'h0);

        // R1: reset mid-run
        @(negedge clk);
        set_cfg(3'b000, 6'b10_10_10, 3'b111, 0, 0, 0, 0, 0, 0);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1", "oe after reset", 8'(pad_oe), 8'h0);
        chk("R1", "iflag after reset", 8'(iflag), 8'h0);

        done = 1;
        finish_run();
    end

endmodule